// File: doc/BRIEF.md
# Circulant Shift Interleaver

This block sits between the lane-parallel storage banks and the lane-parallel processing units of a quasi-cyclic LDPC decoder. Each non-null sub-matrix of the parity-check matrix is a shifted identity of size Z×Z. It carries its own rotation amount. On the way into the processing units, the block cyclically rotates a vector of Z soft values (LLRs) by that amount. On the way back it applies the opposite rotation, so that updated values land in the bank lanes they came from.

The physical lane count `MAX_Z` is fixed at build time. The expansion factor `z_size` is chosen per request and can be any value from 1 to `MAX_Z`, including values that are not a power of two, such as 24 or 96. Lane `i` of both vectors occupies bits `[i*LLR_W +: LLR_W]`. A request is presented for one cycle with `in_valid`. Its result is registered and appears one clock later together with `out_valid`.

Top module: `qc_circulant_rotator`

## Requirements
- R1: With `in_dir` = 0 (forward) and a legal request, output lane i equals input lane (i + shift_off) mod z_size for every i below z_size; this holds for z_size = 24, z_size = 96 and values that are not powers of two.
- R2: With `in_dir` = 1 (inverse) and a legal request, output lane i equals input lane (i − shift_off) mod z_size for every i below z_size.
- R3: Applying a forward rotation and then an inverse rotation with the same offset and z_size returns the original lanes below z_size.
- R4: Output lanes at index z_size and above are always zero, and the contents of input lanes at z_size and above have no effect on the output.
- R5: An offset of zero, in either direction, passes lanes below z_size through unchanged.
- R6: The result of a request accepted with `in_valid` high appears on `out_llr` on the next rising edge, and `out_valid` is high in exactly that cycle.
- R7: In a cycle without `in_valid`, `out_valid` goes low on the next edge and `out_llr` keeps its previous value, whatever the other inputs do.
- R8: A malformed request (z_size = 0, z_size > MAX_Z, or shift_off ≥ z_size) still raises `out_valid`, with every output lane zero.
- R9: While `rst_n` is low, `out_valid` is 0 and `out_llr` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_dir | input | 1 | 0 = forward (interleave), 1 = inverse (deinterleave) |
| z_size | input | $clog2(MAX_Z+1) | Runtime expansion factor |
| shift_off | input | $clog2(MAX_Z+1) | Rotation offset of the sub-matrix |
| in_llr | input | MAX_Z*LLR_W | Input lanes, lane i at bits [i*LLR_W +: LLR_W] |
| out_valid | output | 1 | Registered result present |
| out_llr | output | MAX_Z*LLR_W | Rotated lanes, same lane layout |

## Verification
The assertions check the following on every cycle. The valid timing and the hold of the data when no request is present are checked each cycle. So is the rule that unused upper lanes leave zero. An offset of zero must pass the active lanes through. Malformed requests must clear every lane. Lane 0 of each forward result is checked against the input lane selected by the offset. The full lane-by-lane mapping in both directions needs the bench's scenarios. The same holds for the wrap point at several non-power-of-two sizes, the forward-then-inverse round trip, and the independence from garbage in the upper input lanes. The bench checks these against its own model.

// File: rtl/qcr_pkg.sv
package qcr_pkg;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_INV = 1'b1
    } rot_dir_e;

    function automatic int unsigned amt_width(int unsigned lanes);
        return $clog2(lanes + 1);
    endfunction

endpackage

// File: rtl/qcr_shift_calc.sv
module qcr_shift_calc
    import qcr_pkg::*;
#(
    parameter int unsigned MAX_Z = 96,
    parameter int unsigned ZW    = amt_width(MAX_Z)
) (
    input  logic          dir_i,
    input  logic [ZW-1:0] z_i,
    input  logic [ZW-1:0] off_i,
    output logic [ZW-1:0] down_amt_o,
    output logic [ZW-1:0] up_amt_o,
    output logic          legal_o
);

    rot_dir_e dir;

    always_comb begin
        dir        = rot_dir_e'(dir_i);
        legal_o    = (z_i != '0) && (z_i <= ZW'(MAX_Z)) && (off_i < z_i);
        down_amt_o = '0;
        up_amt_o   = '0;
        if (legal_o) begin
            unique case (dir)
                DIR_FWD: down_amt_o = off_i;
                DIR_INV: down_amt_o = (off_i == '0) ? '0 : z_i - off_i;
            endcase
            up_amt_o = z_i - down_amt_o;
        end
    end

endmodule

// File: rtl/qcr_lane_shifter.sv
module qcr_lane_shifter #(
    parameter int unsigned LANES       = 96,
    parameter int unsigned W           = 8,
    parameter int unsigned AW          = 7,
    parameter bit          TOWARD_HIGH = 1'b0
) (
    input  logic [LANES-1:0][W-1:0] d_i,
    input  logic [AW-1:0]           amt_i,
    output logic [LANES-1:0][W-1:0] q_o
);

    logic [LANES-1:0][W-1:0] cur;
    logic [LANES-1:0][W-1:0] nxt;

    generate
        if (TOWARD_HIGH) begin : g_up
            always_comb begin
                cur = d_i;
                nxt = d_i;
                for (int k = 0; k < AW; k++) begin
                    nxt = cur;
                    if (amt_i[k]) begin
                        for (int i = 0; i < LANES; i++) begin
                            if (i >= (1 << k)) nxt[i] = cur[i - (1 << k)];
                            else               nxt[i] = '0;
                        end
                    end
                    cur = nxt;
                end
                q_o = cur;
            end
        end else begin : g_down
            always_comb begin
                cur = d_i;
                nxt = d_i;
                for (int k = 0; k < AW; k++) begin
                    nxt = cur;
                    if (amt_i[k]) begin
                        for (int i = 0; i < LANES; i++) begin
                            if (i + (1 << k) < LANES) nxt[i] = cur[i + (1 << k)];
                            else                      nxt[i] = '0;
                        end
                    end
                    cur = nxt;
                end
                q_o = cur;
            end
        end
    endgenerate

endmodule

// File: rtl/qcr_wrap_merge.sv
module qcr_wrap_merge #(
    parameter int unsigned LANES = 96,
    parameter int unsigned W     = 8,
    parameter int unsigned ZW    = 7
) (
    input  logic [LANES-1:0][W-1:0] down_i,
    input  logic [LANES-1:0][W-1:0] up_i,
    input  logic [ZW-1:0]           z_i,
    input  logic [ZW-1:0]           down_amt_i,
    input  logic                    legal_i,
    output logic [LANES-1:0][W-1:0] lanes_o
);

    localparam int unsigned RW = ZW + 1;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [RW-1:0] reach;
        logic          active;
        logic          wrapped;

        assign reach   = RW'(i) + {1'b0, down_amt_i};
        assign active  = legal_i && (RW'(i) < {1'b0, z_i});
        assign wrapped = reach >= {1'b0, z_i};
        assign lanes_o[i] = !active ? '0 : (wrapped ? up_i[i] : down_i[i]);
    end

endmodule

// File: rtl/qc_circulant_rotator.sv
module qc_circulant_rotator
    import qcr_pkg::*;
#(
    parameter int unsigned MAX_Z = 96,
    parameter int unsigned LLR_W = 8,
    localparam int unsigned ZW   = amt_width(MAX_Z),
    localparam int unsigned VW   = MAX_Z * LLR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_dir,
    input  logic [ZW-1:0] z_size,
    input  logic [ZW-1:0] shift_off,
    input  logic [VW-1:0] in_llr,
    output logic          out_valid,
    output logic [VW-1:0] out_llr
);

    logic [MAX_Z-1:0][LLR_W-1:0] in_lanes;
    logic [MAX_Z-1:0][LLR_W-1:0] down_lanes;
    logic [MAX_Z-1:0][LLR_W-1:0] up_lanes;
    logic [MAX_Z-1:0][LLR_W-1:0] merged;
    logic [ZW-1:0]               down_amt;
    logic [ZW-1:0]               up_amt;
    logic                        legal;

    assign in_lanes = in_llr;

    qcr_shift_calc #(.MAX_Z(MAX_Z), .ZW(ZW)) u_calc (
        .dir_i      (in_dir),
        .z_i        (z_size),
        .off_i      (shift_off),
        .down_amt_o (down_amt),
        .up_amt_o   (up_amt),
        .legal_o    (legal)
    );

    qcr_lane_shifter #(.LANES(MAX_Z), .W(LLR_W), .AW(ZW), .TOWARD_HIGH(1'b0)) u_down (
        .d_i   (in_lanes),
        .amt_i (down_amt),
        .q_o   (down_lanes)
    );

    qcr_lane_shifter #(.LANES(MAX_Z), .W(LLR_W), .AW(ZW), .TOWARD_HIGH(1'b1)) u_up (
        .d_i   (in_lanes),
        .amt_i (up_amt),
        .q_o   (up_lanes)
    );

    qcr_wrap_merge #(.LANES(MAX_Z), .W(LLR_W), .ZW(ZW)) u_merge (
        .down_i     (down_lanes),
        .up_i       (up_lanes),
        .z_i        (z_size),
        .down_amt_i (down_amt),
        .legal_i    (legal),
        .lanes_o    (merged)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_llr   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_llr <= merged;
        end
    end

endmodule

// File: rtl/qcr_chk.sv
module qcr_chk #(
    parameter int unsigned MAX_Z = 96,
    parameter int unsigned LLR_W = 8,
    localparam int unsigned ZW   = $clog2(MAX_Z + 1),
    localparam int unsigned VW   = MAX_Z * LLR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_dir,
    input logic [ZW-1:0] z_size,
    input logic [ZW-1:0] shift_off,
    input logic [VW-1:0] in_llr,
    input logic          out_valid,
    input logic [VW-1:0] out_llr
);

    logic [MAX_Z-1:0][LLR_W-1:0] in_l;
    logic [MAX_Z-1:0][LLR_W-1:0] out_l;
    logic [MAX_Z-1:0][LLR_W-1:0] in_masked;
    logic [LLR_W-1:0]            lane_at_off;
    logic [ZW-1:0]               z_q;
    logic                        ok_req;
    logic                        hi_clear;

    assign in_l   = in_llr;
    assign out_l  = out_llr;
    assign ok_req = (z_size != '0) && (int'(z_size) <= MAX_Z) && (shift_off < z_size);

    always_comb begin
        for (int i = 0; i < MAX_Z; i++) in_masked[i] = (i < int'(z_size)) ? in_l[i] : '0;
        lane_at_off = (int'(shift_off) < MAX_Z) ? in_l[shift_off] : '0;
        hi_clear = 1'b1;
        for (int i = 0; i < MAX_Z; i++)
            if (i >= int'(z_q) && out_l[i] != '0) hi_clear = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        z_q <= ZW'(MAX_Z);
        else if (in_valid) z_q <= z_size;
    end

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_llr));

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> hi_clear);

    // R5
    zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ok_req && shift_off == '0) |=> (out_llr == $past(in_masked)));

    // R8
    bad_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ok_req) |=> (out_llr == '0));

    // R1
    fwd_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ok_req && !in_dir) |=> (out_l[0] == $past(lane_at_off)));

endmodule

bind qc_circulant_rotator qcr_chk #(.MAX_Z(MAX_Z), .LLR_W(LLR_W)) u_qcr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_dir    (in_dir),
    .z_size    (z_size),
    .shift_off (shift_off),
    .in_llr    (in_llr),
    .out_valid (out_valid),
    .out_llr   (out_llr)
);

// File: tb/test_qc_circulant_rotator.sv
`timescale 1ns/1ps
module test_qc_circulant_rotator;

    localparam int N  = 96;
    localparam int W  = 8;
    localparam int ZW = $clog2(N + 1);
    localparam int VW = N * W;

    typedef struct packed {
        logic       dir;
        logic [6:0] z;
        logic [6:0] off;
        logic [7:0] seed;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 7'd24, 7'd5,  8'd3},
        '{1'b1, 7'd24, 7'd5,  8'd11},
        '{1'b0, 7'd24, 7'd23, 8'd40},
        '{1'b1, 7'd24, 7'd1,  8'd77},
        '{1'b0, 7'd96, 7'd0,  8'd5},
        '{1'b1, 7'd96, 7'd95, 8'd9},
        '{1'b0, 7'd96, 7'd50, 8'd121},
        '{1'b1, 7'd7,  7'd3,  8'd200},
        '{1'b0, 7'd1,  7'd0,  8'd66},
        '{1'b0, 7'd64, 7'd63, 8'd13},
        '{1'b1, 7'd24, 7'd0,  8'd150},
        '{1'b0, 7'd95, 7'd94, 8'd31}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_dir = 1'b0;
    logic [ZW-1:0] z_size = '0;
    logic [ZW-1:0] shift_off = '0;
    logic [VW-1:0] in_llr = '0;
    logic          out_valid;
    logic [VW-1:0] out_llr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    qc_circulant_rotator #(.MAX_Z(N), .LLR_W(W)) i_qc_circulant_rotator (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_dir    (in_dir),
        .z_size    (z_size),
        .shift_off (shift_off),
        .in_llr    (in_llr),
        .out_valid (out_valid),
        .out_llr   (out_llr)
    );

    function automatic logic [VW-1:0] fill(int seed, int z, int junk);
        logic [VW-1:0] v;
        for (int i = 0; i < N; i++)
            v[i*W +: W] = (i < z) ? W'((i * 37 + seed) % 256) : W'(8'hA5 ^ i ^ junk);
        return v;
    endfunction

    function automatic logic [VW-1:0] model(logic dir, int z, int off, logic [VW-1:0] v);
        logic [VW-1:0] r = '0;
        int src;
        if (z < 1 || z > N || off >= z) return r;
        for (int i = 0; i < z; i++) begin
            src = dir ? (i - off + z) % z : (i + off) % z;
            r[i*W +: W] = v[src*W +: W];
        end
        return r;
    endfunction

    task automatic chk_vec(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic apply(logic dir, int z, int off, logic [VW-1:0] v,
                         output logic [VW-1:0] res, output logic vld);
        @(negedge clk);
        in_valid  = 1'b1;
        in_dir    = dir;
        z_size    = ZW'(z);
        shift_off = ZW'(off);
        in_llr    = v;
        @(negedge clk);
        in_valid  = 1'b0;
        res = out_llr;
        vld = out_valid;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [VW-1:0] v, a, b, held;
        logic vld;

        // R9: reset state
        repeat (2) @(negedge clk);
        chk_bit("R9 out_valid in reset", out_valid, 1'b0);
        chk_vec("R9 out_llr in reset", out_llr, '0);
        rst_n = 1'b1;

        // R1 R2 R5 R4 table walk
        for (int k = 0; k < NV; k++) begin
            v = fill(int'(VECS[k].seed), int'(VECS[k].z), k);
            apply(VECS[k].dir, int'(VECS[k].z), int'(VECS[k].off), v, a, vld);
            chk_bit("R6 out_valid after request", vld, 1'b1);
            if (VECS[k].off == 0)
                chk_vec("R5 zero offset", a, model(1'b0, int'(VECS[k].z), 0, v));
            else if (VECS[k].dir)
                chk_vec("R2 inverse rotation", a, model(1'b1, int'(VECS[k].z), int'(VECS[k].off), v));
            else
                chk_vec("R1 forward rotation", a, model(1'b0, int'(VECS[k].z), int'(VECS[k].off), v));
        end

        // R3: round trip
        v = fill(19, 24, 1);
        apply(1'b0, 24, 7, v, a, vld);
        apply(1'b1, 24, 7, a, b, vld);
        chk_vec("R3 round trip z24", b, model(1'b0, 24, 0, v));
        v = fill(88, 96, 2);
        apply(1'b0, 96, 61, v, a, vld);
        apply(1'b1, 96, 61, a, b, vld);
        chk_vec("R3 round trip z96", b, model(1'b0, 96, 0, v));

        // R4: upper input lanes have no effect
        apply(1'b0, 24, 9, fill(4, 24, 3), a, vld);
        apply(1'b0, 24, 9, fill(4, 24, 200), b, vld);
        chk_vec("R4 upper lanes ignored", b, a);
        chk_vec("R4 upper lanes zero", a, model(1'b0, 24, 9, fill(4, 24, 3)));

        // R7: hold without request
        held = a;
        @(negedge clk);
        in_dir = 1'b1;
        z_size = ZW'(50);
        shift_off = ZW'(3);
        in_llr = fill(99, 96, 9);
        @(negedge clk);
        @(negedge clk);
        chk_bit("R7 out_valid low when idle", out_valid, 1'b0);
        chk_vec("R7 out_llr held when idle", out_llr, held);

        // R8: malformed requests
        apply(1'b0, 0, 0, fill(1, 96, 0), a, vld);
        chk_bit("R8 valid on z=0", vld, 1'b1);
        chk_vec("R8 z=0 zero lanes", a, '0);
        apply(1'b1, 100, 2, fill(2, 96, 0), a, vld);
        chk_vec("R8 z above max zero lanes", a, '0);
        apply(1'b0, 24, 24, fill(3, 24, 0), a, vld);
        chk_vec("R8 offset equal z zero lanes", a, '0);

        // R9: reset in mid-stream clears output
        apply(1'b0, 24, 2, fill(5, 24, 0), a, vld);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_bit("R9 out_valid after reset", out_valid, 1'b0);
        chk_vec("R9 out_llr after reset", out_llr, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule